// File: doc/BRIEF.md
# Timestamped Host Write Capture FIFO

This block watches single-byte writes from a host to a debug code port and keeps them for later inspection by an embedded controller. Every accepted byte goes into a 16-entry FIFO. When tagging is turned on, the byte is stored with the current value of a free-running 24-bit timestamp counter. The timestamp counter advances on a prescaled version of a 6 MHz enable input, so it can be slowed to a half, a quarter or an eighth of that rate.

The controller reaches the block over a simple 32-bit register bus with strobes that last one cycle. A read of the data window gives back one 32-bit word and removes the oldest entry from the FIFO. In that word the captured byte sits in bits [7:0] and its timestamp in bits [31:8]. The other registers configure the block, report fill and overflow state, give read and write access to the timestamp counter, and switch the block on and off.

Read data is registered: it appears on `bus_rdata` one clock after the read strobe and holds until the next read. The level interrupt `irq` is high whenever the FIFO holds at least the selected threshold number of entries.

Top module: `hostcap_top`

## Requirements
- R1: A captured host byte is popped as the word {timestamp[23:0], byte[7:0]}. Entries come out oldest first. The timestamp field is the counter value at capture time while tagging (config bit 5) is 1, and zero while tagging is 0. The data window is at offset 0x100.
- R2: The FIFO holds 16 entries. A host write arriving while 16 entries are held is dropped and leaves the stored entries unchanged. It also sets the overrun flag, which is status bit 1. This holds even when a pop happens in the same cycle.
- R3: Overrun stays set through status reads and through pops. It is cleared by a flush (writing 1 to config bit 1, offset 0x104), which also empties the FIFO, and by reset. A host write that arrives in the same cycle as a flush is discarded.
- R4: Status bit 0 (offset 0x108) is 1 exactly while the FIFO holds at least one entry. Reading status changes nothing.
- R5: A read of the data window while the FIFO is empty returns 0 and leaves the FIFO state unchanged.
- R6: `irq` is high while the occupancy is at least the threshold selected by config bits [7:6]: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R7: The count register (offset 0x10C) holds the timestamp counter in bits [31:8], and its bits [7:0] read as 0. A write loads the counter and restarts the prescaler. While `tick_6m` is high, config bits [4:3] = 00, 01, 10 or 11 make the counter advance once every 1, 2, 4 or 8 cycles. The counter wraps from 0xFFFFFF to 0.
- R8: Writing 1 to config bit 2 sets the timestamp counter to zero.
- R9: Activate bit 0 (offset 0x330) enables capture, and its reset value is 0. While it is 0, host writes are ignored.
- R10: When a host write and a data window read fall in the same cycle on a FIFO that is neither empty nor full, the oldest entry is returned, the new byte is stored, and the occupancy is unchanged.
- R11: Config bits [7:3] read back as written. Bits 2, 1 and 0 read as 0. All fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | One-cycle strobe for a snooped host write |
| host_wr_data | input | 8 | Byte written by the host |
| tick_6m | input | 1 | 6 MHz timebase enable, one cycle per period |
| bus_addr | input | 12 | Register byte offset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Threshold interrupt level |

## Verification
A push and a pop can land in the same clock edge. The bench provokes this by raising the host write strobe and the data window read strobe in one cycle, once on a partly filled FIFO and once on a full one. The returned word and every word popped afterwards are compared against a scoreboard queue that models the FIFO independently. The level seen through status and `irq` is also checked, to show that in the first case the occupancy held steady, and in the full case the push was dropped while the pop went through.

// File: rtl/hostcap_pkg.sv
package hostcap_pkg;

    localparam int BYTE_W  = 8;
    localparam int STAMP_W = 24;
    localparam int WORD_W  = BYTE_W + STAMP_W;
    localparam int BUS_AW  = 12;

    localparam logic [BUS_AW-1:0] OFS_POP   = 12'h100;
    localparam logic [BUS_AW-1:0] OFS_CFG   = 12'h104;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 12'h108;
    localparam logic [BUS_AW-1:0] OFS_STAMP = 12'h10C;
    localparam logic [BUS_AW-1:0] OFS_ACT   = 12'h330;

    // config bit positions
    localparam int CB_FLUSH = 1;
    localparam int CB_ZERO  = 2;
    localparam int CB_RATE  = 3;
    localparam int CB_TAG   = 5;
    localparam int CB_LVL   = 6;

    typedef enum logic [1:0] {
        LVL_ONE      = 2'd0,
        LVL_FOUR     = 2'd1,
        LVL_EIGHT    = 2'd2,
        LVL_FOURTEEN = 2'd3
    } level_sel_e;

    function automatic int level_of(input level_sel_e sel);
        case (sel)
            LVL_ONE:   return 1;
            LVL_FOUR:  return 4;
            LVL_EIGHT: return 8;
            default:   return 14;
        endcase
    endfunction

endpackage

// File: rtl/hostcap_fifo.sv
module hostcap_fifo #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              empty_o,
    output logic              full_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    ptr_state_t        st_d, st_q;
    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        do_pop  = pop_i && (st_q.count != '0);
        do_push = push_i && (st_q.count != FULL_CNT);
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                mem_d[st_q.wr_ptr] = wdata_i;
                st_d.wr_ptr        = bump(st_q.wr_ptr);
            end
            if (do_pop) begin
                st_d.rd_ptr = bump(st_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign head_o  = mem_q[st_q.rd_ptr];
    assign count_o = st_q.count;
    assign empty_o = (st_q.count == '0);
    assign full_o  = (st_q.count == FULL_CNT);

    // R2: occupancy never exceeds the depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);

    // R10: simultaneous push and pop on a partly filled FIFO keeps the level
    a_r10_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i && st_q.count != '0 && st_q.count != FULL_CNT)
        |=> $stable(st_q.count));

    // R5: a pop request on an empty FIFO moves no pointer
    a_r5_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !flush_i && st_q.count == '0)
        |=> ($stable(st_q.rd_ptr) && st_q.count == '0));

endmodule

// File: rtl/hostcap_stamp.sv
module hostcap_stamp #(
    parameter int STAMP_W = 24,
    parameter int RATE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [RATE_W-1:0]  rate_i,
    input  logic               zero_i,
    input  logic               load_i,
    input  logic [STAMP_W-1:0] load_val_i,
    output logic [STAMP_W-1:0] stamp_o
);

    localparam int MAX_SHIFT = (1 << RATE_W) - 1;
    localparam int PRE_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [STAMP_W-1:0] stamp;
    } stamp_state_t;

    stamp_state_t     st_d, st_q;
    logic [PRE_W-1:0] pre_last;
    logic             advance;

    always_comb begin
        st_d     = st_q;
        pre_last = (PRE_W'(1) << rate_i) - 1'b1;
        advance  = tick_i && (st_q.pre >= pre_last);
        if (load_i) begin
            st_d.stamp = load_val_i;
            st_d.pre   = '0;
        end else if (zero_i) begin
            st_d.stamp = '0;
            st_d.pre   = '0;
        end else if (tick_i) begin
            if (advance) begin
                st_d.pre   = '0;
                st_d.stamp = st_q.stamp + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp_o = st_q.stamp;

    // R8: a zero strobe clears the counter
    a_r8_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_i && !load_i) |=> (st_q.stamp == '0));

    // R7: without tick, load or zero the counter holds
    a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i && !zero_i) |=> $stable(st_q.stamp));

    // R7: the counter wraps to zero from all ones
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_i && advance && st_q.stamp == '1) |=> (st_q.stamp == '0));

endmodule

// File: rtl/hostcap_regs.sv
module hostcap_regs
    import hostcap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [BYTE_W-1:0]  host_wr_data,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic [WORD_W-1:0]  head_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               empty_i,
    input  logic               full_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output logic               push_o,
    output logic               pop_o,
    output logic               flush_o,
    output logic [WORD_W-1:0]  entry_o,
    output logic [1:0]         rate_o,
    output logic               zero_o,
    output logic               load_o,
    output logic [STAMP_W-1:0] load_val_o,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               irq_o
);

    typedef struct packed {
        level_sel_e        lvl;
        logic              tag_en;
        logic [1:0]        rate;
        logic              active;
        logic              ovr;
        logic [WORD_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       cfg_wr;
    logic       host_ok;
    logic [CNT_W-1:0] lvl_cnt;

    always_comb begin
        st_d       = st_q;
        cfg_wr     = bus_wr_en && (bus_addr == OFS_CFG);
        flush_o    = cfg_wr && bus_wdata[CB_FLUSH];
        zero_o     = cfg_wr && bus_wdata[CB_ZERO];
        load_o     = bus_wr_en && (bus_addr == OFS_STAMP);
        load_val_o = bus_wdata[WORD_W-1:BYTE_W];
        host_ok    = host_wr_en && st_q.active;
        push_o     = host_ok && !flush_o;
        pop_o      = bus_rd_en && (bus_addr == OFS_POP);
        entry_o    = {(st_q.tag_en ? stamp_i : {STAMP_W{1'b0}}), host_wr_data};
        rate_o     = st_q.rate;

        if (cfg_wr) begin
            st_d.rate   = bus_wdata[CB_RATE +: 2];
            st_d.tag_en = bus_wdata[CB_TAG];
            st_d.lvl    = level_sel_e'(bus_wdata[CB_LVL +: 2]);
        end
        if (bus_wr_en && (bus_addr == OFS_ACT)) begin
            st_d.active = bus_wdata[0];
        end

        if (flush_o) begin
            st_d.ovr = 1'b0;
        end else if (host_ok && full_i) begin
            st_d.ovr = 1'b1;
        end

        if (bus_rd_en) begin
            case (bus_addr)
                OFS_POP:   st_d.rdata = empty_i ? '0 : head_i;
                OFS_CFG:   st_d.rdata = {{(WORD_W-8){1'b0}}, st_q.lvl, st_q.tag_en,
                                         st_q.rate, 3'b000};
                OFS_STAT:  st_d.rdata = {{(WORD_W-2){1'b0}}, st_q.ovr, !empty_i};
                OFS_STAMP: st_d.rdata = {stamp_i, {BYTE_W{1'b0}}};
                OFS_ACT:   st_d.rdata = {{(WORD_W-1){1'b0}}, st_q.active};
                default:   st_d.rdata = '0;
            endcase
        end

        lvl_cnt = CNT_W'(level_of(st_q.lvl));
        irq_o   = (count_i >= lvl_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

    // R3: overrun persists until a flush
    a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !flush_o) |=> st_q.ovr);

    // R9: while inactive, host writes never raise the occupancy
    a_r9_inactive_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !pop_o && !flush_o) |=> (count_i == $past(count_i)));

    // R6: an empty FIFO never interrupts
    a_r6_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty_i |-> !irq_o);

    // R5: a read of the empty data window returns zero
    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o && empty_i) |=> (st_q.rdata == '0));

endmodule

// File: rtl/hostcap_top.sv
module hostcap_top
    import hostcap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [BYTE_W-1:0]  host_wr_data,
    input  logic               tick_6m,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               push, pop, flush, zero, load, empty, full;
    logic [WORD_W-1:0]  entry, head;
    logic [CNT_W-1:0]   count;
    logic [1:0]         rate;
    logic [STAMP_W-1:0] stamp, load_val;

    hostcap_regs #(.DEPTH(DEPTH)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .bus_addr     (bus_addr),
        .bus_wr_en    (bus_wr_en),
        .bus_rd_en    (bus_rd_en),
        .bus_wdata    (bus_wdata),
        .head_i       (head),
        .count_i      (count),
        .empty_i      (empty),
        .full_i       (full),
        .stamp_i      (stamp),
        .push_o       (push),
        .pop_o        (pop),
        .flush_o      (flush),
        .entry_o      (entry),
        .rate_o       (rate),
        .zero_o       (zero),
        .load_o       (load),
        .load_val_o   (load_val),
        .rdata_o      (bus_rdata),
        .irq_o        (irq)
    );

    hostcap_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .flush_i (flush),
        .wdata_i (entry),
        .head_o  (head),
        .count_o (count),
        .empty_o (empty),
        .full_o  (full)
    );

    hostcap_stamp #(.STAMP_W(STAMP_W), .RATE_W(2)) stamp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_6m),
        .rate_i     (rate),
        .zero_i     (zero),
        .load_i     (load),
        .load_val_i (load_val),
        .stamp_o    (stamp)
    );

endmodule

// File: tb/hostcap_top_tb_top.sv
module hostcap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wr_data = '0;
    logic        tick_6m = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    hostcap_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .tick_6m(tick_6m), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [11:0] A_POP = 12'h100, A_CFG = 12'h104, A_STAT = 12'h108,
                            A_STAMP = 12'h10C, A_ACT = 12'h330;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // scoreboard model
    logic [31:0] sb[$];
    bit          m_act = 0;
    bit          m_ovr = 0;
    logic [23:0] m_stamp = '0;
    logic [1:0]  c_lvl = 0;
    logic        c_tag = 0;
    logic [1:0]  c_rate = 0;

    function automatic int lvl_val(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [31:0] cfgv(input logic [1:0] lvl, input logic tag,
                                         input logic [1:0] rate, input logic zero,
                                         input logic fl);
        return {24'h0, lvl, tag, rate, zero, fl, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] lvl, input logic tag, input logic [1:0] rate);
        c_lvl = lvl; c_tag = tag; c_rate = rate;
        bus_write(A_CFG, cfgv(lvl, tag, rate, 1'b0, 1'b0));
    endtask

    task automatic do_flush();
        bus_write(A_CFG, cfgv(c_lvl, c_tag, c_rate, 1'b0, 1'b1));
        sb.delete(); m_ovr = 0;
    endtask

    task automatic load_stamp(input logic [23:0] v);
        bus_write(A_STAMP, {v, 8'hAB});
        m_stamp = v;
    endtask

    // driver: one host write, expected word queued when the model accepts it
    task automatic host_push(input logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        if (m_act) begin
            if (sb.size() < 16) sb.push_back({(c_tag ? m_stamp : 24'h0), d});
            else m_ovr = 1;
        end
    endtask

    // monitor: pop one word and compare with the scoreboard
    task automatic pop_check(input string req);
        logic [31:0] got, exp;
        bus_read(A_POP, got);
        exp = (sb.size() > 0) ? sb.pop_front() : 32'h0;
        check(req, got, exp);
    endtask

    task automatic stat_check(input string req);
        logic [31:0] got;
        bus_read(A_STAT, got);
        check(req, got, {30'h0, m_ovr, (sb.size() != 0)});
    endtask

    task automatic irq_check(input string req);
        check(req, {31'h0, irq}, {31'h0, (sb.size() >= lvl_val(c_lvl))});
    endtask

    // push and pop in one cycle
    task automatic push_pop(input logic [7:0] d, input string req);
        logic [31:0] got, exp;
        bit          was_full;
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = d;
        bus_addr = A_POP; bus_rd_en = 1'b1;
        @(negedge clk);
        got = bus_rdata;
        host_wr_en = 1'b0; bus_rd_en = 1'b0;
        was_full = (sb.size() == 16);
        exp = (sb.size() > 0) ? sb.pop_front() : 32'h0;
        if (was_full) m_ovr = 1;
        else sb.push_back({(c_tag ? m_stamp : 24'h0), d});
        check(req, got, exp);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_6m = 1'b1;
        repeat (n) @(negedge clk);
        tick_6m = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        bus_read(A_STAT, r);  check("R4 reset status", r, 32'h0);
        bus_read(A_CFG, r);   check("R11 reset config", r, 32'h0);
        bus_read(A_STAMP, r); check("R7 reset count", r, 32'h0);
        bus_read(A_ACT, r);   check("R9 reset activate", r, 32'h0);
        check("R6 reset irq", {31'h0, irq}, 32'h0);

        // R9: inactive block ignores host writes
        host_push(8'h11);
        stat_check("R9 inactive write ignored");
        pop_check("R9 inactive nothing stored");

        bus_write(A_ACT, 32'h1);
        m_act = 1;
        bus_read(A_ACT, r); check("R9 activate readback", r, 32'h1);

        // R1 and R6: tagged captures, threshold of four
        set_cfg(2'd1, 1'b1, 2'd0);
        bus_read(A_CFG, r); check("R11 config readback", r, cfgv(2'd1, 1'b1, 2'd0, 0, 0));
        load_stamp(24'h123456);
        host_push(8'hA1); host_push(8'hA2); host_push(8'hA3);
        irq_check("R6 three below four");
        stat_check("R4 not empty");
        load_stamp(24'h00BEEF);
        host_push(8'hA4);
        irq_check("R6 four reaches four");
        for (int i = 0; i < 4; i++) pop_check("R1 tagged pop order");
        stat_check("R4 empty after drain");
        irq_check("R6 drained");

        // R5: empty read, then ordinary use
        set_cfg(2'd0, 1'b1, 2'd0);
        pop_check("R5 empty read zero");
        host_push(8'h5A);
        irq_check("R6 one reaches one");
        pop_check("R5 pointers intact");

        // R1: tagging off gives a zero stamp field
        set_cfg(2'd3, 1'b0, 2'd0);
        host_push(8'hC1); host_push(8'hC2);
        pop_check("R1 untagged"); pop_check("R1 untagged second");

        // R2 and R6: fill to sixteen
        for (int i = 0; i < 13; i++) host_push(8'h40 + 8'(i));
        irq_check("R6 thirteen below fourteen");
        host_push(8'h4D);
        irq_check("R6 fourteen reaches fourteen");
        set_cfg(2'd2, 1'b0, 2'd0);
        irq_check("R6 threshold eight");
        host_push(8'h4E); host_push(8'h4F);
        host_push(8'hEE);
        stat_check("R2 overrun on full");
        stat_check("R3 status read keeps overrun");
        push_pop(8'hEF, "R2 full push with pop");
        stat_check("R2 dropped with pop");
        while (sb.size() > 0) pop_check("R2 entries unchanged");
        stat_check("R3 overrun after drain");
        do_flush();
        stat_check("R3 flush clears overrun");

        // R3: flush with entries pending
        host_push(8'h77); host_push(8'h78);
        do_flush();
        stat_check("R3 flush empties");
        pop_check("R3 nothing after flush");

        // R3: host write in the same cycle as a flush is discarded
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = 8'h99;
        bus_addr = A_CFG; bus_wdata = cfgv(c_lvl, c_tag, c_rate, 0, 1); bus_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; bus_wr_en = 1'b0;
        stat_check("R3 flush beats host write");

        // R10: push and pop in one cycle
        set_cfg(2'd0, 1'b1, 2'd0);
        load_stamp(24'h0A0B0C);
        host_push(8'hD1); host_push(8'hD2);
        push_pop(8'hD3, "R10 simultaneous returns oldest");
        stat_check("R10 level kept");
        pop_check("R10 second"); pop_check("R10 pushed byte");
        stat_check("R10 empty at end");

        // R7: prescaler rates
        for (int rt = 0; rt < 4; rt++) begin
            set_cfg(2'd0, 1'b0, 2'(rt));
            load_stamp(24'h0);
            run_ticks(40);
            bus_read(A_STAMP, r);
            check("R7 rate divide", r, {24'(40 >> rt), 8'h00});
        end
        set_cfg(2'd0, 1'b0, 2'd0);
        load_stamp(24'hFFFFFF);
        run_ticks(3);
        bus_read(A_STAMP, r); check("R7 wrap", r, {24'h000002, 8'h00});

        // R8: zero strobe
        load_stamp(24'h345678);
        bus_write(A_CFG, cfgv(c_lvl, c_tag, c_rate, 1'b1, 1'b0));
        bus_read(A_STAMP, r); check("R8 zero strobe", r, 32'h0);
        bus_read(A_CFG, r); check("R11 strobes read zero", r, cfgv(c_lvl, c_tag, c_rate, 0, 0));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule